// File: doc/BRIEF.md
# Serial-In Latched-Parallel-Out Shift Register

This block turns a serial bit stream into a parallel word. Bits enter one at a time on each rising edge of a shift strobe. A separate transfer strobe copies the whole shift word into a holding register, and that register alone drives the parallel outputs. Because of this split, the downstream logic keeps seeing a stable word while the next one is being shifted in.

The block runs on a single system clock. The shift and transfer strobes are treated as slow, asynchronous-looking inputs. Each one passes through a synchronizer and a rising-edge detector, so one strobe edge causes exactly one action.

Other controls:
- An active-low clear empties only the shift stages.
- An active-low output enable selects between driving the parallel word and releasing it. Release is modelled as a data bus plus a per-bit enable vector.
- The last shift stage is brought out as a serial output. Several blocks can be chained through it to form longer words.

Top module: `sipo_latch_top`

## Requirements
- R1: On each detected rising edge of `shiftStrobe` with `clearN` high, `serIn` enters stage 0, stage n moves to stage n+1, and the top stage's old value is dropped.
- R2: On each detected rising edge of `xferStrobe` with `clearN` high, all shift stages are copied into the holding register. `parOut[i]` then shows stage i, where stage 0 holds the most recently shifted bit.
- R3: The holding register keeps its value through any number of shifts and clears until the next detected transfer edge.
- R4: While `clearN` is low, every shift stage is forced to 0 on each clock, shift edges have no effect, and the holding register is not changed.
- R5: When `outEnN` is 1, `parOe` is all zeros and `parOut` reads all zeros. When `outEnN` is 0, `parOe` is all ones and `parOut` equals the holding register.
- R6: `serOut` always equals the top shift stage. It does not depend on `xferStrobe` or `outEnN`, and it reads 0 one clock after `clearN` is sampled low.
- R7: A transfer edge detected while `clearN` is low loads all zeros into the holding register.
- R8: Each strobe passes through a two-flop synchronizer and an edge detector. A strobe that rises just after a falling clock edge takes effect at the third following rising clock edge. A strobe held high for any length of time causes exactly one action. Strobes must stay high and low for at least two clocks each.
- R9: When a shift edge and a transfer edge are detected in the same clock, the holding register captures the shift word from before that shift.
- R10: A synchronous active-high `rst` clears the shift stages, the holding register and the strobe synchronizers.
- R11: When the `serOut` of one block feeds the `serIn` of a second block that shares its strobes, the pair behaves as one 16-stage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data bit |
| shiftStrobe | input | 1 | Shift strobe; acts on its rising edge |
| xferStrobe | input | 1 | Transfer strobe; acts on its rising edge |
| clearN | input | 1 | Clear of the shift stages, active low |
| outEnN | input | 1 | Parallel output enable, active low |
| parOut | output | WIDTH | Parallel data bus from the holding register |
| parOe | output | WIDTH | Per-bit drive enable; 0 means high impedance |
| serOut | output | 1 | Top shift stage, used for chaining |

## Verification
The assertions assume that each strobe obeys the two-clock minimum high and low width. Under that rule a detected pulse never lasts more than one clock, and a pulse is always preceded by a quiet clock.

The bench keeps to that rule by design:
- It holds every strobe high for three clocks and then low for three clocks.
- It holds `serIn` and `clearN` steady across the whole window.
- It changes `outEnN` only at the start of an operation.

Under these conditions, the cycle in which each action lands is fixed, and the reference queue model can track both chained blocks exactly.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // One-clock action pulses handed from control to datapath
  typedef struct packed {
    logic shiftPulse;
    logic xferPulse;
  } ctrlStrobes_t;

  localparam int STROBE_SHIFT = 0;
  localparam int STROBE_XFER  = 1;
  localparam int NUM_STROBES  = 2;
endpackage

// File: rtl/sipo_strobe_sync.sv
module sipo_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic risePulse
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
      lastLevel <= syncChain[SYNC_STAGES-1];
    end
  end

  assign risePulse = syncChain[SYNC_STAGES-1] & ~lastLevel;
endmodule

// File: rtl/sipo_ctrl.sv
module sipo_ctrl
  import sipo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftStrobe,
  input  logic         xferStrobe,
  output ctrlStrobes_t strb
);
  logic [NUM_STROBES-1:0] rawVec;
  logic [NUM_STROBES-1:0] pulseVec;

  assign rawVec[STROBE_SHIFT] = shiftStrobe;
  assign rawVec[STROBE_XFER]  = xferStrobe;

  for (genvar s = 0; s < NUM_STROBES; s++) begin : g_sync
    sipo_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst      (rst),
      .rawIn    (rawVec[s]),
      .risePulse(pulseVec[s])
    );
  end

  assign strb.shiftPulse = pulseVec[STROBE_SHIFT];
  assign strb.xferPulse  = pulseVec[STROBE_XFER];
endmodule

// File: rtl/sipo_datapath.sv
module sipo_datapath
  import sipo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic             serIn,
  input  logic             clearN,
  input  logic             outEnN,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parOe,
  output logic             serOut
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      holdReg  <= '0;
    end else begin
      if (!clearN)
        shiftReg <= '0;
      else if (strb.shiftPulse)
        shiftReg <= {shiftReg[TOP-1:0], serIn};
      // capture uses the pre-shift word; a clear zeroes the captured value
      if (strb.xferPulse)
        holdReg <= clearN ? shiftReg : '0;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign parOe[i]  = ~outEnN;
    assign parOut[i] = holdReg[i] & ~outEnN;
  end

  assign serOut = shiftReg[TOP];
endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top
  import sipo_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serIn,
  input  logic             shiftStrobe,
  input  logic             xferStrobe,
  input  logic             clearN,
  input  logic             outEnN,
  output logic [WIDTH-1:0] parOut,
  output logic [WIDTH-1:0] parOe,
  output logic             serOut
);
  ctrlStrobes_t strb;

  sipo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shiftStrobe(shiftStrobe),
    .xferStrobe (xferStrobe),
    .strb       (strb)
  );

  sipo_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .serIn (serIn),
    .clearN(clearN),
    .outEnN(outEnN),
    .parOut(parOut),
    .parOe (parOe),
    .serOut(serOut)
  );
endmodule

// File: rtl/sipo_latch_checker.sv
module sipo_latch_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clearN,
  input logic             outEnN,
  input logic [WIDTH-1:0] parOut,
  input logic [WIDTH-1:0] parOe,
  input logic             serOut,
  input logic             shiftPulse,
  input logic             xferPulse
);
  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
    !clearN |=> (serOut == 1'b0));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!xferPulse && !outEnN) ##1 !outEnN |-> $stable(parOut));

  assert_released_R5: assert property (@(posedge clk) disable iff (rst)
    outEnN |-> (parOe == '0 && parOut == '0));

  assert_driven_R5: assert property (@(posedge clk) disable iff (rst)
    !outEnN |-> (parOe == '1));

  assert_serout_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!shiftPulse && clearN) |=> $stable(serOut));

  assert_clear_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    (xferPulse && !clearN) |=> (outEnN || parOut == '0));

  assert_single_shift_R8: assert property (@(posedge clk) disable iff (rst)
    shiftPulse |=> !shiftPulse);

  assert_single_xfer_R8: assert property (@(posedge clk) disable iff (rst)
    xferPulse |=> !xferPulse);
endmodule

bind sipo_latch_top sipo_latch_checker #(.WIDTH(WIDTH)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .clearN    (clearN),
  .outEnN    (outEnN),
  .parOut    (parOut),
  .parOe     (parOe),
  .serOut    (serOut),
  .shiftPulse(strb.shiftPulse),
  .xferPulse (strb.xferPulse)
);

// File: tb/test_sipo_latch_top.sv
module test_sipo_latch_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0;
  logic shiftStrobe = 1'b0;
  logic xferStrobe = 1'b0;
  logic clearN = 1'b1;
  logic outEnN = 1'b0;
  logic [W-1:0] parOutA, parOeA, parOutB, parOeB;
  logic serOutA, serOutB;

  always #10 clk = ~clk;

  sipo_latch_top #(.WIDTH(W)) i_sipo_latch_top (
    .clk(clk), .rst(rst), .serIn(serIn), .shiftStrobe(shiftStrobe),
    .xferStrobe(xferStrobe), .clearN(clearN), .outEnN(outEnN),
    .parOut(parOutA), .parOe(parOeA), .serOut(serOutA));

  sipo_latch_top #(.WIDTH(W)) i_sipo_latch_top_b (
    .clk(clk), .rst(rst), .serIn(serOutA), .shiftStrobe(shiftStrobe),
    .xferStrobe(xferStrobe), .clearN(clearN), .outEnN(outEnN),
    .parOut(parOutB), .parOe(parOeB), .serOut(serOutB));

  // vector fields: {serIn, shift, xfer, clearN, outEnN}
  localparam int NV = 22;
  localparam logic [4:0] VEC [NV] = '{
    5'b1_1_0_1_0, 5'b0_1_0_1_0, 5'b1_1_0_1_0, 5'b1_1_0_1_0,
    5'b0_1_0_1_0, 5'b0_1_0_1_0, 5'b1_1_0_1_0, 5'b0_1_0_1_0,
    5'b0_0_1_1_0,
    5'b1_1_0_1_0, 5'b1_1_0_1_1, 5'b1_1_0_1_0, 5'b0_1_0_1_0,
    5'b0_1_0_1_1, 5'b1_1_0_1_0, 5'b0_1_0_1_0, 5'b1_1_0_1_0,
    5'b0_1_1_1_0,
    5'b0_0_1_1_0,
    5'b0_0_0_0_0,
    5'b1_1_0_1_0,
    5'b0_0_1_0_0
  };

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [2*W-1:0] chain = '0;
  logic [W-1:0] sA = '0, sB = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R1 R6 R11 serOut A", {15'd0, serOutA}, {15'd0, chain[W-1]});
    chk("R1 R6 R11 serOut B", {15'd0, serOutB}, {15'd0, chain[2*W-1]});
    chk("R2 R3 R9 R11 parOut A", {8'd0, parOutA}, {8'd0, outEnN ? 8'd0 : sA});
    chk("R2 R3 R9 R11 parOut B", {8'd0, parOutB}, {8'd0, outEnN ? 8'd0 : sB});
    chk("R5 parOe A", {8'd0, parOeA}, {8'd0, outEnN ? 8'd0 : 8'hFF});
    chk("R5 parOe B", {8'd0, parOeB}, {8'd0, outEnN ? 8'd0 : 8'hFF});
  endtask

  // reference model of one operation, built from the requirements
  task automatic modelOp(input logic sin, input logic sh, input logic xf, input logic clr);
    logic [2*W-1:0] pre = chain;
    if (!clr) begin
      if (xf) begin sA = '0; sB = '0; end           // R7
      chain = '0;                                   // R4
    end else begin
      if (xf) begin sA = pre[W-1:0]; sB = pre[2*W-1:W]; end  // R9 pre-shift
      if (sh) chain = {pre[2*W-2:0], sin};
    end
  endtask

  task automatic applyOp(input logic [4:0] v, input int highCycles);
    @(negedge clk);
    serIn = v[4]; clearN = v[1]; outEnN = v[0];
    shiftStrobe = v[3]; xferStrobe = v[2];
    repeat (highCycles) @(negedge clk);
    shiftStrobe = 1'b0; xferStrobe = 1'b0;
    repeat (3) @(negedge clk);
    modelOp(v[4], v[3], v[2], v[1]);
    checkAll();
    clearN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset parOut A", {8'd0, parOutA}, 16'd0);
    chk("R10 reset serOut B", {15'd0, serOutB}, 16'd0);
    chk("R10 reset parOe A", {8'd0, parOeA}, 16'h00FF);

    for (int k = 0; k < NV; k++) applyOp(VEC[k], 3);

    // R8: strobe held high for many clocks shifts only once
    applyOp(5'b1_1_0_1_0, 12);
    applyOp(5'b0_0_1_1_0, 3);

    // R8: transfer latency of three rising edges
    applyOp(5'b0_1_0_1_0, 3);
    @(negedge clk);
    xferStrobe = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 transfer not yet visible", {8'd0, parOutA}, {8'd0, sA});
    modelOp(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 transfer visible at third edge", {8'd0, parOutA}, {8'd0, sA});
    xferStrobe = 1'b0;
    repeat (3) @(negedge clk);

    // R10: reset mid-stream clears both registers
    applyOp(5'b1_1_0_1_0, 3);
    applyOp(5'b0_0_1_1_0, 3);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chain = '0; sA = '0; sB = '0;
    @(negedge clk);
    chk("R10 mid reset parOut A", {8'd0, parOutA}, 16'd0);
    chk("R10 mid reset serOut A", {15'd0, serOutA}, 16'd0);
    checkAll();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule